// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the configuration step of a vector processor: given a requested element count and a candidate type word, it settles the active vector length (vl), the element-type state (element width, register grouping, tail and mask policies) and the invalid-configuration flag. The register form takes its requested count from a source register and its type word from a register or an immediate. The immediate form takes a 5-bit count and a 10-bit type field. Decode-stage flags tell the unit whether the source register and the destination register are the zero register. These flags select among the keep-length, maximum-length and explicit-count behaviours.

Each accepted request completes in one cycle. Every output comes from a register and changes on the edge that follows the strobe. On success the unit writes the new state, pulses a write-back of the new vl together with a dirty mark for the vector state and a clear of the start index. If vector execution is disabled, the unit raises an illegal-instruction pulse with the faulting address and leaves its state untouched.

Top module: `vcfg_unit`

## Requirements
- R1: A strobe with `vec_enable` low raises `illegal` for one cycle with `illegal_pc` equal to `pc_in`. It leaves vl and the type state unchanged and pulses neither `rd_valid`, `vs_dirty` nor `vstart_clr`.
- R2: A type word is rejected in any of these cases: a bit above bit 7 is set; the width field (bits 5:3) is above 3; the grouping field (bits 2:0) equals 4; or the element width exceeds ELEN times the grouping factor (or exceeds ELEN). A rejected word sets the invalid flag, sets vl to 0 and returns 0 to the destination.
- R3: In the register form with a nonzero source register, the requested count is the low 32 bits of `avl_in`, and vl is the smaller of that count and VLMAX.
- R4: In the register form with a zero source register and a nonzero destination, vl becomes the new VLMAX.
- R5: With both registers zero, the unit compares the new VLMAX with the VLMAX of the current state, where an invalid current state counts as 0. If they are equal, vl is kept (bounded by the new VLMAX). If they differ, the result is the invalid state with vl 0.
- R6: In the immediate form (`cfg_imm` high), the count is `imm_avl` and the type word is `imm_vtype` zero-extended. The two register-zero flags are ignored.
- R7: VLMAX equals VLEN × LMUL / SEW. Width codes 0 to 3 mean SEW 8, 16, 32 and 64. Grouping codes 0 to 3 mean LMUL 1, 2, 4 and 8, and codes 5 to 7 mean LMUL 1/8, 1/4 and 1/2.
- R8: `vtype_out` reads back bits 7:0 of the accepted word (mask policy bit 7, tail policy bit 6, width 5:3, grouping 2:0) with all higher bits clear. In the invalid state it reads back only the top bit set.
- R9: Every request with vector execution enabled (accepted or rejected) pulses `rd_valid`, `vs_dirty` and `vstart_clr` for one cycle, with `rd_wdata` equal to the new vl.
- R10: After reset the state is invalid: vl 0, `vill_out` high, and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Request strobe, one request per cycle |
| cfg_imm | input | 1 | High selects the immediate form |
| vec_enable | input | 1 | Vector execution permitted |
| rs1_zero | input | 1 | Source register is the zero register |
| rd_zero | input | 1 | Destination register is the zero register |
| avl_in | input | XLEN | Source register value (requested count) |
| vtype_in | input | XLEN | Type word, register form |
| imm_avl | input | 5 | Requested count, immediate form |
| imm_vtype | input | 10 | Type field, immediate form |
| pc_in | input | XLEN | Address of the request's instruction |
| vl_out | output | VL_W | Current vector length |
| vtype_out | output | XLEN | Current type state read-back |
| vill_out | output | 1 | Configuration invalid |
| rd_valid | output | 1 | Destination write pulse |
| rd_wdata | output | XLEN | Value for the destination register |
| vs_dirty | output | 1 | Vector state dirty pulse |
| vstart_clr | output | 1 | Start index clear pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| illegal_pc | output | XLEN | Faulting address |

## Verification
All results (vl, type read-back, invalid flag, write-back value and the three pulses) are due exactly one rising edge after the strobe cycle. The illegal pulse and its address follow the same timing. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It samples every output at that falling edge, when the pulses are still high, and again one cycle later to see that they have cleared. The keep-length cases depend on the state left by the row before, so the table rows run in a fixed order.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   // Decoded type-word fields held as architectural state
   typedef struct packed {
      logic       vma;
      logic       vta;
      logic [2:0] vsew;
      logic [2:0] vlmul;
   } vtype_f_t;

   // log2 of the grouping factor, -3..3 (code 4 is reserved)
   function automatic int lmul_log2(input logic [2:0] code);
      return code[2] ? int'(code) - 8 : int'(code);
   endfunction

   // log2 of the element width in bits
   function automatic int sew_log2(input logic [2:0] code);
      return 3 + int'(code);
   endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
   import vcfg_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int ELEN = 64
) (
   input  logic [XLEN-1:0] raw,
   output vtype_f_t        fields,
   output logic            legal
);
   localparam int ELEN_L2 = $clog2(ELEN);

   if (ELEN != 32 && ELEN != 64) begin : g_bad_elen
      $error("vcfg_decode: ELEN must be 32 or 64");
   end

   logic rsvd_hi;
   int   lm, sw, cap;

   always_comb begin
      fields.vma   = raw[7];
      fields.vta   = raw[6];
      fields.vsew  = raw[5:3];
      fields.vlmul = raw[2:0];
      rsvd_hi      = |raw[XLEN-1:8];
      lm           = lmul_log2(raw[2:0]);
      sw           = sew_log2(raw[5:3]);
      cap          = ELEN_L2 + ((lm < 0) ? lm : 0);
      legal        = !rsvd_hi && !raw[5] && (raw[2:0] != 3'd4) && (sw <= cap);
   end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
   import vcfg_pkg::*;
#(
   parameter int VLEN = 128,
   parameter int VL_W = $clog2(VLEN) + 1
) (
   input  vtype_f_t        fields,
   input  logic            legal,
   output logic [VL_W-1:0] vlmax
);
   localparam int VLEN_L2 = $clog2(VLEN);

   if ((1 << VLEN_L2) != VLEN) begin : g_bad_vlen
      $error("vcfg_vlmax: VLEN must be a power of two");
   end

   int         shift;
   logic [7:0] sh;

   always_comb begin
      shift = VLEN_L2 + lmul_log2(fields.vlmul) - sew_log2(fields.vsew);
      sh    = (shift < 0) ? 8'd0 : 8'(shift);
      vlmax = legal ? (VL_W'(1) << sh) : '0;
   end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int VLEN = 128,
   parameter int ELEN = 64,
   localparam int VL_W = $clog2(VLEN) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_valid,
   input  logic            cfg_imm,
   input  logic            vec_enable,
   input  logic            rs1_zero,
   input  logic            rd_zero,
   input  logic [XLEN-1:0] avl_in,
   input  logic [XLEN-1:0] vtype_in,
   input  logic [4:0]      imm_avl,
   input  logic [9:0]      imm_vtype,
   input  logic [XLEN-1:0] pc_in,
   output logic [VL_W-1:0] vl_out,
   output logic [XLEN-1:0] vtype_out,
   output logic            vill_out,
   output logic            rd_valid,
   output logic [XLEN-1:0] rd_wdata,
   output logic            vs_dirty,
   output logic            vstart_clr,
   output logic            illegal,
   output logic [XLEN-1:0] illegal_pc
);
   localparam int AVL_W = 32;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("vcfg_unit: XLEN must be 32 or 64");
   end
   if (VLEN < ELEN || VLEN > 65536) begin : g_bad_vlen
      $error("vcfg_unit: VLEN must lie in ELEN..65536");
   end

   // architectural state
   vtype_f_t        cur_q;
   logic            vill_q;
   logic [VL_W-1:0] vl_q;
   logic            wb_q, ill_q;
   logic [XLEN-1:0] ill_pc_q;

   // new type word and its decode
   logic [XLEN-1:0] raw_vt;
   vtype_f_t        new_f;
   logic            new_ok;
   logic [VL_W-1:0] new_vlmax, old_vlmax;

   assign raw_vt = cfg_imm ? XLEN'(imm_vtype) : vtype_in;

   vcfg_decode #(.XLEN(XLEN), .ELEN(ELEN)) u_dec (
      .raw(raw_vt), .fields(new_f), .legal(new_ok)
   );

   vcfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) u_new_max (
      .fields(new_f), .legal(new_ok), .vlmax(new_vlmax)
   );

   vcfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) u_old_max (
      .fields(cur_q), .legal(!vill_q), .vlmax(old_vlmax)
   );

   // requested count: low AVL_W bits of the register, or the immediate
   logic [AVL_W-1:0] avl_req;
   if (XLEN > AVL_W) begin : g_avl_trunc
      assign avl_req = cfg_imm ? AVL_W'(imm_avl) : avl_in[AVL_W-1:0];
   end else begin : g_avl_full
      assign avl_req = cfg_imm ? AVL_W'(imm_avl) : avl_in;
   end

   function automatic logic [VL_W-1:0] clamp(input logic [AVL_W-1:0] req,
                                             input logic [VL_W-1:0]  lim);
      return (req < AVL_W'(lim)) ? VL_W'(req) : lim;
   endfunction

   logic            nx_fail;
   logic [VL_W-1:0] nx_vl;

   always_comb begin
      nx_fail = 1'b0;
      nx_vl   = '0;
      if (!new_ok) begin
         nx_fail = 1'b1;
      end else if (cfg_imm || !rs1_zero) begin
         nx_vl = clamp(avl_req, new_vlmax);
      end else if (!rd_zero) begin
         nx_vl = new_vlmax;
      end else if (new_vlmax != old_vlmax) begin
         nx_fail = 1'b1;
      end else begin
         nx_vl = clamp(AVL_W'(vl_q), new_vlmax);
      end
   end

   logic accept, reject;
   assign accept = cfg_valid && vec_enable;
   assign reject = cfg_valid && !vec_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         vill_q   <= 1'b1;
         vl_q     <= '0;
         wb_q     <= 1'b0;
         ill_q    <= 1'b0;
         ill_pc_q <= '0;
      end else begin
         wb_q  <= accept;
         ill_q <= reject;
         if (reject) ill_pc_q <= pc_in;
         if (accept) begin
            vill_q <= nx_fail;
            cur_q  <= nx_fail ? '0 : new_f;
            vl_q   <= nx_fail ? '0 : nx_vl;
         end
      end
   end

   assign vl_out     = vl_q;
   assign vill_out   = vill_q;
   assign vtype_out  = vill_q ? {1'b1, {(XLEN-1){1'b0}}} : XLEN'(cur_q);
   assign rd_valid   = wb_q;
   assign rd_wdata   = XLEN'(vl_q);
   assign vs_dirty   = wb_q;
   assign vstart_clr = wb_q;
   assign illegal    = ill_q;
   assign illegal_pc = ill_pc_q;

   // R1
   disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ill_q |-> ($stable(vl_q) && $stable(vill_q) && $stable(cur_q) && !wb_q));

   // R1
   disabled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !vec_enable) |=> (ill_q && !wb_q));

   // R2
   vill_zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vill_q |-> (vl_q == '0));

   // R7
   vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= old_vlmax);

   // R9
   wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && vec_enable) |=> (wb_q && rd_wdata == XLEN'(vl_q)));

   // R9
   wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && vec_enable) |=> !wb_q);

endmodule

// File: tb/vcfg_unit_bench.sv
module vcfg_unit_bench;
   localparam int XLEN = 64;
   localparam int VLEN = 128;
   localparam int ELEN = 64;
   localparam int VL_W = $clog2(VLEN) + 1;
   localparam logic [63:0] VILL_RB = 64'h8000_0000_0000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_valid = 1'b0, cfg_imm = 1'b0, vec_enable = 1'b1;
   logic            rs1_zero = 1'b0, rd_zero = 1'b0;
   logic [XLEN-1:0] avl_in = '0, vtype_in = '0, pc_in = '0;
   logic [4:0]      imm_avl = '0;
   logic [9:0]      imm_vtype = '0;
   logic [VL_W-1:0] vl_out;
   logic [XLEN-1:0] vtype_out, rd_wdata, illegal_pc;
   logic            vill_out, rd_valid, vs_dirty, vstart_clr, illegal;

   always #5 clk = ~clk;

   vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_vcfg_unit (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_imm(cfg_imm),
      .vec_enable(vec_enable), .rs1_zero(rs1_zero), .rd_zero(rd_zero),
      .avl_in(avl_in), .vtype_in(vtype_in), .imm_avl(imm_avl),
      .imm_vtype(imm_vtype), .pc_in(pc_in), .vl_out(vl_out),
      .vtype_out(vtype_out), .vill_out(vill_out), .rd_valid(rd_valid),
      .rd_wdata(rd_wdata), .vs_dirty(vs_dirty), .vstart_clr(vstart_clr),
      .illegal(illegal), .illegal_pc(illegal_pc)
   );

   typedef struct packed {
      logic        imm;
      logic        rs1z;
      logic        rdz;
      logic [63:0] avl;
      logic [63:0] vt;
      logic [4:0]  iavl;
      logic [9:0]  ivt;
      logic [15:0] evl;
      logic        evill;
      logic [63:0] evt;
   } row_t;

   localparam int NROW = 17;
   localparam row_t TBL [NROW] = '{
      '{1'b0,1'b0,1'b0,64'd10,          64'h00, 5'd0, 10'h000,16'd10, 1'b0,64'h00},   // R3 e8 m1
      '{1'b0,1'b0,1'b0,64'd100,         64'h10, 5'd0, 10'h000,16'd4,  1'b0,64'h10},   // R3 R7 e32 m1 clamp
      '{1'b0,1'b0,1'b0,64'h1_0000_0005, 64'h1B, 5'd0, 10'h000,16'd5,  1'b0,64'h1B},   // R3 upper bits dropped
      '{1'b0,1'b0,1'b0,64'd7,           64'h09, 5'd0, 10'h000,16'd7,  1'b0,64'h09},   // R3 e16 m2
      '{1'b0,1'b1,1'b1,64'd0,           64'h12, 5'd0, 10'h000,16'd7,  1'b0,64'h12},   // R5 same VLMAX keeps vl
      '{1'b0,1'b1,1'b1,64'd0,           64'h10, 5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R5 VLMAX differs
      '{1'b0,1'b1,1'b1,64'd0,           64'h10, 5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R5 invalid current
      '{1'b0,1'b1,1'b0,64'd0,           64'hC5, 5'd0, 10'h000,16'd2,  1'b0,64'hC5},   // R4 R8 mf8 with policies
      '{1'b0,1'b0,1'b0,64'd3,           64'h1F, 5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R2 SEW over ELEN*LMUL
      '{1'b0,1'b0,1'b0,64'd3,           64'h04, 5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R2 reserved grouping
      '{1'b0,1'b0,1'b0,64'd3,           64'h20, 5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R2 reserved width
      '{1'b0,1'b0,1'b0,64'd3,           64'h100,5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R2 bit 8
      '{1'b0,1'b0,1'b0,64'd3,           VILL_RB,5'd0, 10'h000,16'd0,  1'b1,VILL_RB},  // R2 top bit
      '{1'b1,1'b1,1'b1,64'd50,          64'h00, 5'd31,10'h003,16'd31, 1'b0,64'h03},   // R6 flags ignored
      '{1'b1,1'b0,1'b0,64'd0,           64'h00, 5'd5, 10'h200,16'd0,  1'b1,VILL_RB},  // R6 R2 bit 9
      '{1'b1,1'b0,1'b0,64'd9,           64'h00, 5'd0, 10'h000,16'd0,  1'b0,64'h00},   // R6 zero count
      '{1'b0,1'b0,1'b0,64'hFFFF_FFFF,   64'h03, 5'd0, 10'h000,16'd128,1'b0,64'h03}    // R3 R7 e8 m8
   };

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 vl after reset", 64'(vl_out), 64'd0);
      chk("R10 vill after reset", 64'(vill_out), 64'd1);
      chk("R10 pulses after reset", {61'd0, rd_valid, vs_dirty, illegal}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROW; i++) begin
         cfg_valid = 1'b1;
         cfg_imm   = TBL[i].imm;
         rs1_zero  = TBL[i].rs1z;
         rd_zero   = TBL[i].rdz;
         avl_in    = TBL[i].avl;
         vtype_in  = TBL[i].vt;
         imm_avl   = TBL[i].iavl;
         imm_vtype = TBL[i].ivt;
         @(negedge clk);
         cfg_valid = 1'b0;
         // R3 R4 R5 R6 R7 result one edge after the strobe
         chk($sformatf("R3-row%0d vl", i), 64'(vl_out), 64'(TBL[i].evl));
         chk($sformatf("R2-row%0d vill", i), 64'(vill_out), 64'(TBL[i].evill));
         chk($sformatf("R8-row%0d vtype", i), vtype_out, TBL[i].evt);
         chk($sformatf("R9-row%0d rd value", i), rd_wdata, 64'(TBL[i].evl));
         chk($sformatf("R9-row%0d pulses", i), {61'd0, rd_valid, vs_dirty, vstart_clr}, 64'd7);
      end

      // R9 pulses last one cycle only
      @(negedge clk);
      chk("R9 pulses cleared", {61'd0, rd_valid, vs_dirty, vstart_clr}, 64'd0);

      // R1 disabled: flag raised, state held (vl 128, type 0x03)
      vec_enable = 1'b0;
      cfg_valid  = 1'b1;
      cfg_imm    = 1'b0;
      rs1_zero   = 1'b0;
      rd_zero    = 1'b0;
      avl_in     = 64'd1;
      vtype_in   = 64'h10;
      pc_in      = 64'h0000_0000_8000_1234;
      @(negedge clk);
      cfg_valid = 1'b0;
      chk("R1 illegal raised", 64'(illegal), 64'd1);
      chk("R1 faulting address", illegal_pc, 64'h0000_0000_8000_1234);
      chk("R1 vl held", 64'(vl_out), 64'd128);
      chk("R1 vtype held", vtype_out, 64'h03);
      chk("R1 no write-back", {61'd0, rd_valid, vs_dirty, vstart_clr}, 64'd0);
      @(negedge clk);
      chk("R1 illegal one cycle", 64'(illegal), 64'd0);
      vec_enable = 1'b1;

      // R5 keep with equal VLMAX after clamp state: e16 m1... e8 m8 -> e16 m... use e64 m8 vlmax 16 differs from 128
      cfg_valid = 1'b1;
      rs1_zero  = 1'b1;
      rd_zero   = 1'b1;
      vtype_in  = 64'h1B;
      @(negedge clk);
      cfg_valid = 1'b0;
      chk("R5 differing VLMAX gives vill", 64'(vill_out), 64'd1);
      chk("R5 differing VLMAX vl zero", 64'(rd_wdata), 64'd0);

      // R10 reset mid-run returns to invalid state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 vill on second reset", 64'(vill_out), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule